// File: doc/BRIEF.md
# Single-Wire Bus ROM Command Layer

This block is the addressing layer of a slave on a single-wire, open-drain bus. A separate bit-timing engine turns the line waveform into events: a bus-reset event, tagged as standard-speed or fast-speed, and one strobe per finished time slot carrying the bit seen on the line. From those events this layer receives one ROM command byte after every bus reset. It then carries out the chosen addressing exchange against a 64-bit device identity: reading it out, matching it, searching, or skipping it.

Only when that exchange succeeds does the layer assert `sel`. With `sel` set, it takes the next byte as a memory command and hands recognised codes to the memory layer as a one-cycle pulse. Two commands put the bus into fast speed. They do this when their byte completes, so the byte itself is still taken at standard speed. For read slots, the layer tells the bit engine whether to pull the line low through `tx_en` and `tx_bit`. A low `tx_bit` with `tx_en` set means the line is pulled low.

Top module: `swire_rom_layer`

## Requirements
- R1: After `rst_n` is released, `sel`, `fast_mode`, `tx_en` and `mcmd_valid` are 0, and slot strobes are ignored until the first `bus_rst`.
- R2: A bus reset starts reception of an 8-bit ROM command, least significant bit first. A code outside {33h, 55h, F0h, ECh, CCh, 3Ch, 69h} leaves the layer silent (`tx_en`=0) and unselected until the next bus reset, even if further command bytes follow.
- R3: Code 33h drives the 64 identity bits out on the next 64 slots, bit 0 first (`tx_en`=1, `tx_bit`=identity bit), then sets `sel`.
- R4: Code 55h compares the next 64 received bits, bit 0 first, against the identity. A full match sets `sel`. The first mismatching bit leaves the layer silent and unselected.
- R5: Code F0h runs 64 rounds. Each round drives the identity bit, then its complement, then reads a direction bit. A direction bit that differs from the identity bit ends the search silent and unselected. After 64 agreeing rounds `sel` is set.
- R6: Code ECh behaves as F0h when `alarm` is 1 at the slot that completes the byte. Otherwise the layer stays silent and unselected.
- R7: Code CCh sets `sel` at the slot that completes the byte.
- R8: Codes 3Ch and 69h set `fast_mode` exactly at the slot that completes the byte, not earlier. 3Ch then behaves as CCh and 69h as 55h.
- R9: `bus_rst` clears `sel` and restarts command reception. It clears `fast_mode` only when `bus_rst_std` is 1. A reset with `bus_rst_std`=0 keeps `fast_mode`.
- R10: With `sel` set, the next byte is a memory command. For codes {0Fh, AAh, 55h, F0h, A5h, 3Ch, 44h}, `mcmd_valid` pulses for one cycle with the code on `mcmd`. Any other code clears `sel`.
- R11: After a memory command has been forwarded, `sel` stays set and further slots have no effect on this layer until a bus reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rst | input | 1 | One-cycle pulse: bus reset/presence event detected |
| bus_rst_std | input | 1 | Qualifies `bus_rst`: 1 when the reset had standard-speed length |
| slot_stb | input | 1 | One-cycle pulse: a time slot finished |
| slot_bit | input | 1 | Line value sampled in the finished slot |
| dev_id | input | 64 | Device identity, bit 0 sent first |
| alarm | input | 1 | Alarm condition qualifying conditional search |
| sel | output | 1 | Device addressed; memory layer access granted |
| fast_mode | output | 1 | Bus runs at fast speed |
| tx_en | output | 1 | Current slot is a read slot driven by this device |
| tx_bit | output | 1 | Value to present in the current read slot (0 pulls low) |
| mcmd_valid | output | 1 | One-cycle pulse: recognised memory command |
| mcmd | output | 8 | Memory command code, valid with `mcmd_valid` |

## Verification
The bench targets the speed switch at the completing bit of the overdrive commands. A design that switched on the first bits, or one that lost the flag on a fast-speed reset, would show `fast_mode` in the wrong cycle. Match and search runs are cut off by a single wrong bit in the middle of the identity. A design that kept comparing or kept driving would still select, or would still pull the line. Conditional search is tried with the alarm low, where a wrong design answers. Unknown ROM and memory codes are sent to catch a design that grants access anyway, or that picks up a later command byte before any reset.

// File: rtl/swire_rom_pkg.sv
package swire_rom_pkg;

    localparam int CMD_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ROMCMD,
        ST_READ,
        ST_MATCH,
        ST_S_ID,
        ST_S_CMP,
        ST_S_DIR,
        ST_MEMCMD,
        ST_HANDOFF
    } layer_st_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_READ,
        OP_MATCH,
        OP_SEARCH,
        OP_CSEARCH,
        OP_SKIP,
        OP_FSKIP,
        OP_FMATCH
    } rom_op_e;

    localparam logic [CMD_W-1:0] CODE_READ    = 8'h33;
    localparam logic [CMD_W-1:0] CODE_MATCH   = 8'h55;
    localparam logic [CMD_W-1:0] CODE_SEARCH  = 8'hF0;
    localparam logic [CMD_W-1:0] CODE_CSEARCH = 8'hEC;
    localparam logic [CMD_W-1:0] CODE_SKIP    = 8'hCC;
    localparam logic [CMD_W-1:0] CODE_FSKIP   = 8'h3C;
    localparam logic [CMD_W-1:0] CODE_FMATCH  = 8'h69;

    localparam int N_MEM = 7;
    localparam logic [N_MEM-1:0][CMD_W-1:0] MEM_CODES =
        {8'h44, 8'h3C, 8'hA5, 8'hF0, 8'h55, 8'hAA, 8'h0F};

endpackage

// File: rtl/swire_rom_decode.sv
module swire_rom_decode
    import swire_rom_pkg::*;
(
    input  logic [CMD_W-1:0] code,
    output rom_op_e          op
);
    always_comb begin
        unique case (code)
            CODE_READ:    op = OP_READ;
            CODE_MATCH:   op = OP_MATCH;
            CODE_SEARCH:  op = OP_SEARCH;
            CODE_CSEARCH: op = OP_CSEARCH;
            CODE_SKIP:    op = OP_SKIP;
            CODE_FSKIP:   op = OP_FSKIP;
            CODE_FMATCH:  op = OP_FMATCH;
            default:      op = OP_NONE;
        endcase
    end
endmodule

// File: rtl/swire_mem_filter.sv
module swire_mem_filter
    import swire_rom_pkg::*;
(
    input  logic [CMD_W-1:0] code,
    output logic             hit
);
    logic [N_MEM-1:0] eq;

    for (genvar g = 0; g < N_MEM; g++) begin : g_cmp
        assign eq[g] = (code == MEM_CODES[g]);
    end

    assign hit = |eq;
endmodule

// File: rtl/swire_bit_pick.sv
module swire_bit_pick #(
    parameter int W = 64,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    input  logic [IW-1:0] idx,
    output logic          bit_o
);
    assign bit_o = vec[idx];
endmodule

// File: rtl/swire_rom_layer.sv
module swire_rom_layer
    import swire_rom_pkg::*;
#(
    parameter int ID_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_rst,
    input  logic             bus_rst_std,
    input  logic             slot_stb,
    input  logic             slot_bit,
    input  logic [ID_W-1:0]  dev_id,
    input  logic             alarm,
    output logic             sel,
    output logic             fast_mode,
    output logic             tx_en,
    output logic             tx_bit,
    output logic             mcmd_valid,
    output logic [CMD_W-1:0] mcmd
);
    localparam int CNT_W = $clog2(ID_W);
    localparam logic [CNT_W-1:0] LAST_ID   = CNT_W'(ID_W - 1);
    localparam logic [CNT_W-1:0] LAST_BYTE = CNT_W'(CMD_W - 1);

    typedef struct packed {
        layer_st_e        st;
        logic [CNT_W-1:0] cnt;
        logic [CMD_W-1:0] shreg;
        logic             sel;
        logic             fast;
        logic             mvld;
        logic [CMD_W-1:0] mcmd;
    } layer_regs_t;

    layer_regs_t cur_q, nxt_d;

    logic [CMD_W-1:0] shifted;
    logic             id_bit;
    logic             mem_hit;
    rom_op_e          rom_op;

    assign shifted = {slot_bit, cur_q.shreg[CMD_W-1:1]};

    swire_rom_decode i_dec (
        .code (shifted),
        .op   (rom_op)
    );

    swire_mem_filter i_filt (
        .code (shifted),
        .hit  (mem_hit)
    );

    swire_bit_pick #(.W(ID_W)) i_pick (
        .vec   (dev_id),
        .idx   (cur_q.cnt),
        .bit_o (id_bit)
    );

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.mvld = 1'b0;
        if (bus_rst) begin
            nxt_d.st  = ST_ROMCMD;
            nxt_d.cnt = '0;
            nxt_d.sel = 1'b0;
            if (bus_rst_std) nxt_d.fast = 1'b0;
        end else if (slot_stb) begin
            unique case (cur_q.st)
                ST_ROMCMD: begin
                    nxt_d.shreg = shifted;
                    if (cur_q.cnt == LAST_BYTE) begin
                        nxt_d.cnt = '0;
                        unique case (rom_op)
                            OP_READ:    nxt_d.st = ST_READ;
                            OP_MATCH:   nxt_d.st = ST_MATCH;
                            OP_SEARCH:  nxt_d.st = ST_S_ID;
                            OP_CSEARCH: nxt_d.st = alarm ? ST_S_ID : ST_IDLE;
                            OP_SKIP: begin
                                nxt_d.sel = 1'b1;
                                nxt_d.st  = ST_MEMCMD;
                            end
                            OP_FSKIP: begin
                                nxt_d.fast = 1'b1;
                                nxt_d.sel  = 1'b1;
                                nxt_d.st   = ST_MEMCMD;
                            end
                            OP_FMATCH: begin
                                nxt_d.fast = 1'b1;
                                nxt_d.st   = ST_MATCH;
                            end
                            default:    nxt_d.st = ST_IDLE;
                        endcase
                    end else begin
                        nxt_d.cnt = cur_q.cnt + 1'b1;
                    end
                end
                ST_READ: begin
                    if (cur_q.cnt == LAST_ID) begin
                        nxt_d.cnt = '0;
                        nxt_d.sel = 1'b1;
                        nxt_d.st  = ST_MEMCMD;
                    end else begin
                        nxt_d.cnt = cur_q.cnt + 1'b1;
                    end
                end
                ST_MATCH: begin
                    if (slot_bit != id_bit) begin
                        nxt_d.st = ST_IDLE;
                    end else if (cur_q.cnt == LAST_ID) begin
                        nxt_d.cnt = '0;
                        nxt_d.sel = 1'b1;
                        nxt_d.st  = ST_MEMCMD;
                    end else begin
                        nxt_d.cnt = cur_q.cnt + 1'b1;
                    end
                end
                ST_S_ID:  nxt_d.st = ST_S_CMP;
                ST_S_CMP: nxt_d.st = ST_S_DIR;
                ST_S_DIR: begin
                    if (slot_bit != id_bit) begin
                        nxt_d.st = ST_IDLE;
                    end else if (cur_q.cnt == LAST_ID) begin
                        nxt_d.cnt = '0;
                        nxt_d.sel = 1'b1;
                        nxt_d.st  = ST_MEMCMD;
                    end else begin
                        nxt_d.cnt = cur_q.cnt + 1'b1;
                        nxt_d.st  = ST_S_ID;
                    end
                end
                ST_MEMCMD: begin
                    nxt_d.shreg = shifted;
                    if (cur_q.cnt == LAST_BYTE) begin
                        nxt_d.cnt = '0;
                        if (mem_hit) begin
                            nxt_d.mvld = 1'b1;
                            nxt_d.mcmd = shifted;
                            nxt_d.st   = ST_HANDOFF;
                        end else begin
                            nxt_d.sel = 1'b0;
                            nxt_d.st  = ST_IDLE;
                        end
                    end else begin
                        nxt_d.cnt = cur_q.cnt + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{st: ST_IDLE, cnt: '0, shreg: '0, sel: 1'b0,
                       fast: 1'b0, mvld: 1'b0, mcmd: '0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign sel        = cur_q.sel;
    assign fast_mode  = cur_q.fast;
    assign mcmd_valid = cur_q.mvld;
    assign mcmd       = cur_q.mcmd;
    assign tx_en      = (cur_q.st == ST_READ) || (cur_q.st == ST_S_ID) ||
                        (cur_q.st == ST_S_CMP);
    assign tx_bit     = (cur_q.st == ST_S_CMP) ? ~id_bit : id_bit;

    AST_STD_RST_CLEARS_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst && bus_rst_std |=> !fast_mode); // R9
    AST_FAST_RST_KEEPS_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst && !bus_rst_std && fast_mode |=> fast_mode); // R9
    AST_RST_DROPS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst |=> !sel); // R9
    AST_MCMD_WHEN_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        mcmd_valid |-> sel); // R10
    AST_MCMD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        mcmd_valid |=> !mcmd_valid); // R10
    AST_SEL_AT_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel) |-> $past(slot_stb)); // R3
    AST_FAST_AT_CMD_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fast_mode) |-> $past(slot_stb) && $past(cur_q.st) == ST_ROMCMD); // R8
    AST_SILENT_UNSEL_TX: assert property (@(posedge clk) disable iff (!rst_n)
        tx_en |-> !sel); // R5
endmodule

// File: tb/test_swire_rom_layer.sv
`timescale 1ns/1ps
module test_swire_rom_layer;

    localparam logic [63:0] ID = 64'hD35A_C107_4E92_6B21;

    typedef struct packed {
        logic [7:0] code;
        logic       alm;
        logic       e_sel;
        logic       e_fast;
        logic       e_tx;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{8'h33, 1'b0, 1'b0, 1'b0, 1'b1},  // R3 read starts driving
        '{8'h55, 1'b0, 1'b0, 1'b0, 1'b0},  // R4 match listens
        '{8'hF0, 1'b0, 1'b0, 1'b0, 1'b1},  // R5 search drives
        '{8'hEC, 1'b1, 1'b0, 1'b0, 1'b1},  // R6 alarm high
        '{8'hEC, 1'b0, 1'b0, 1'b0, 1'b0},  // R6 alarm low silent
        '{8'hCC, 1'b0, 1'b1, 1'b0, 1'b0},  // R7 skip
        '{8'h3C, 1'b0, 1'b1, 1'b1, 1'b0},  // R8 fast skip
        '{8'h69, 1'b0, 1'b0, 1'b1, 1'b0},  // R8 fast match
        '{8'hA5, 1'b0, 1'b0, 1'b0, 1'b0},  // R2 unknown
        '{8'h00, 1'b0, 1'b0, 1'b0, 1'b0}   // R2 unknown
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_rst = 1'b0, bus_rst_std = 1'b0, slot_stb = 1'b0, slot_bit = 1'b1;
    logic alarm = 1'b0;
    logic sel, fast_mode, tx_en, tx_bit, mcmd_valid;
    logic [7:0] mcmd;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    swire_rom_layer i_swire_rom_layer (
        .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .bus_rst_std(bus_rst_std),
        .slot_stb(slot_stb), .slot_bit(slot_bit), .dev_id(ID), .alarm(alarm),
        .sel(sel), .fast_mode(fast_mode), .tx_en(tx_en), .tx_bit(tx_bit),
        .mcmd_valid(mcmd_valid), .mcmd(mcmd)
    );

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic slot(input logic b);
        @(negedge clk) slot_bit = b; slot_stb = 1'b1;
        @(negedge clk) slot_stb = 1'b0; slot_bit = 1'b1;
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 0; i < 8; i++) slot(b[i]);
    endtask

    task automatic rd_bit(output logic v);
        v = tx_en ? tx_bit : 1'b1;
        slot(v);
    endtask

    task automatic breset(input logic std);
        @(negedge clk) bus_rst = 1'b1; bus_rst_std = std;
        @(negedge clk) bus_rst = 1'b0; bus_rst_std = 1'b0;
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic v;
        logic [63:0] acc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 sel", sel, 0);
        chk("R1 fast", fast_mode, 0);
        chk("R1 tx_en", tx_en, 0);
        chk("R1 mcmd_valid", mcmd_valid, 0);
        send_byte(8'hCC);
        chk("R1 slots before bus reset ignored", sel, 0);

        // table walk
        for (int k = 0; k < NV; k++) begin
            breset(1'b1);
            alarm = VECS[k].alm;
            send_byte(VECS[k].code);
            chk("R2 table sel", sel, VECS[k].e_sel);
            chk("R8 table fast", fast_mode, VECS[k].e_fast);
            chk("R2 table tx_en", tx_en, VECS[k].e_tx);
        end
        alarm = 1'b0;

        // R2 unknown then a valid byte stays ignored
        breset(1'b1);
        send_byte(8'h12);
        send_byte(8'hCC);
        chk("R2 later byte ignored", sel, 0);

        // R3 read all bits
        breset(1'b1);
        send_byte(8'h33);
        acc = '0;
        for (int i = 0; i < 64; i++) begin
            rd_bit(v);
            acc[i] = v;
        end
        chk("R3 identity read", acc, ID);
        chk("R3 selected", sel, 1);

        // R10 recognised memory command
        send_byte(8'hAA);
        chk("R10 mcmd_valid", mcmd_valid, 1);
        chk("R10 mcmd code", mcmd, 8'hAA);
        @(negedge clk);
        chk("R10 pulse width", mcmd_valid, 0);
        // R11 further slots ignored
        send_byte(8'h12);
        chk("R11 sel kept", sel, 1);
        chk("R11 no pulse", mcmd_valid, 0);

        // R4 full match
        breset(1'b1);
        send_byte(8'h55);
        for (int i = 0; i < 64; i++) slot(ID[i]);
        chk("R4 match selects", sel, 1);
        // R10 unknown memory code
        send_byte(8'h12);
        chk("R10 unknown mem drops sel", sel, 0);
        chk("R10 unknown mem no pulse", mcmd_valid, 0);

        // R4 mismatch at bit 10
        breset(1'b1);
        send_byte(8'h55);
        for (int i = 0; i < 64; i++) slot(i == 10 ? ~ID[i] : ID[i]);
        chk("R4 mismatch not selected", sel, 0);
        chk("R4 mismatch silent", tx_en, 0);

        // R5 full search
        breset(1'b1);
        send_byte(8'hF0);
        acc = '0;
        for (int i = 0; i < 64; i++) begin
            rd_bit(v);
            acc[i] = v;
            if (i == 20) chk("R5 complement slot", {tx_en, tx_bit}, {1'b1, ~ID[i]});
            rd_bit(v);
            slot(ID[i]);
        end
        chk("R5 search id", acc, ID);
        chk("R5 search selects", sel, 1);

        // R5 wrong direction at bit 5
        breset(1'b1);
        send_byte(8'hF0);
        for (int i = 0; i < 6; i++) begin
            rd_bit(v);
            rd_bit(v);
            slot(i == 5 ? ~ID[i] : ID[i]);
        end
        chk("R5 dropped silent", tx_en, 0);
        chk("R5 dropped unselected", sel, 0);

        // R6 conditional search without alarm stays silent
        breset(1'b1);
        alarm = 1'b0;
        send_byte(8'hEC);
        rd_bit(v);
        chk("R6 no answer", v, 1);
        chk("R6 unselected", sel, 0);

        // R8 fast switch timing
        breset(1'b1);
        for (int i = 0; i < 7; i++) slot(8'h3C >> i);
        chk("R8 not fast before last bit", fast_mode, 0);
        slot(1'b0);
        chk("R8 fast at completion", fast_mode, 1);
        // R9 fast-speed reset keeps flag
        breset(1'b0);
        chk("R9 fast kept", fast_mode, 1);
        chk("R9 sel cleared", sel, 0);
        // R8 fast match then identity
        send_byte(8'h69);
        for (int i = 0; i < 64; i++) slot(ID[i]);
        chk("R8 fast match selects", sel, 1);
        breset(1'b1);
        chk("R9 standard reset clears fast", fast_mode, 0);

        // R7 skip then memory code
        send_byte(8'hCC);
        chk("R7 skip selects", sel, 1);
        send_byte(8'h44);
        chk("R10 code 44", {mcmd_valid, mcmd}, {1'b1, 8'h44});

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule